// File: doc/BRIEF.md
# DDR SDRAM Command Decoder

This block sits on the device side of a double-data-rate SDRAM model. On each rising clock edge it takes in the clock-enable level, the active-low chip-select, row-strobe, column-strobe and write-enable inputs, the bank address and the address bus. One clock later it presents exactly one command strobe from a one-hot vector. It keeps the clock-enable level from the previous edge, so it can tell entry into and exit from power-down and self refresh apart from ordinary commands. A small record of open rows per bank sets the kind of power-down that is entered.

When a base mode-register load is decoded, the op-code on the address bus is checked. A legal op-code updates the burst length, the burst ordering and the read latency. An illegal one raises an error flag and leaves the stored settings as they were. Extended mode-register loads are reported as a strobe only. Every control pattern without a defined meaning comes out as the no-operation strobe.

Top module: `ddr_cmd_decoder`

## Requirements
- R1: Every output cycle has exactly one bit of `cmdOneHot` set. During and just after reset only bit 0 (no-operation) is set. Each strobe appears one clock edge after the edge that sampled its inputs.
- R2: With clock enable high on both the previous and the current edge, chip-select high (code 1xxx on csN,rasN,casN,weN) or code 0111 gives bit 0 (no-operation).
- R3: With clock enable high on both edges, the codes decode as follows. Code 0000 with bank 0 gives bit 1 (base mode load). Code 0000 with bank 1 gives bit 2 (extended mode load). Code 0000 with bank 2 or 3 gives bit 0. Code 0001 gives bit 3 (refresh), 0011 gives bit 6 (activate), 0101 gives bit 7 (read), 0100 gives bit 8 (write) and 0110 gives bit 9 (burst stop). `cmdBank` repeats the bank of activate, read, write and single-bank precharge.
- R4: For read and write, `autoPre` equals address bit 10; it is low for every other command. Code 0010 (precharge) gives bit 11 (all banks) when address bit 10 is high and bit 10 (one bank) when it is low.
- R5: Clock enable falling between two edges while code 0001 is present gives bit 4 (self-refresh entry). While clock enable stays low the output is bit 0 whatever the code. The next rise gives bit 5 (self-refresh exit).
- R6: Clock enable falling with any other code gives power-down entry: bit 13 if any bank has an open row, otherwise bit 12. The code present at the falling edge and all codes while clock enable stays low are not executed. The rise that ends a power-down gives bit 14.
- R7: A row opens on activate. It closes on single-bank precharge of its bank, on precharge-all, and on a read or write to its bank with bit 10 high. No row is open after reset.
- R8: A base mode load with a legal op-code updates the settings. Address bits 2:0 set the burst length: codes 1, 2 and 3 give 2, 4 and 8 on `burstLen`. Bit 3 sets `burstType` (0 sequential, 1 interleaved). Bits 6:4 set the latency in half cycles on `casLatHalf`: code 2 gives 4, code 3 gives 6 and code 6 gives 5. `modeErr` is cleared.
- R9: An op-code is illegal if the burst-length code is not 1, 2 or 3, if the latency code is not 2, 3 or 6, or if any address bit 12:7 is set. An illegal base mode load sets `modeErr` and leaves all three settings unchanged. An extended mode load changes neither the settings nor `modeErr`.
- R10: After reset `burstLen` is 4, `burstType` is 0, `casLatHalf` is 6 and `modeErr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable level |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address bus; bit 10 is the auto-precharge / all-banks bit, low bits carry the mode op-code |
| cmdOneHot | output | 15 | One-hot command strobe, bit positions as in R1 to R6 |
| cmdBank | output | 2 | Bank of the current bank command |
| autoPre | output | 1 | Auto-precharge with read or write |
| burstLen | output | 4 | Stored burst length (2, 4 or 8) |
| burstType | output | 1 | Stored burst ordering, 1 = interleaved |
| casLatHalf | output | 4 | Stored read latency in half cycles |
| modeErr | output | 1 | Last base mode load carried an illegal op-code |

## Verification
The assertions assume that clock enable stays high for the whole of reset and on the first edge after it. They also assume that the inputs are stable around the rising edge. The stimulus changes every input only on the falling edge and holds `cke` high until reset has ended. It also assumes nothing about the legality of a command sequence. The normal-mode sweep therefore runs all sixteen codes against every bank and both levels of bit 10 in any order, and the open-row record follows whatever that order produces.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;
  localparam int ADDR_W  = 13;
  localparam int AP_BIT  = 10;
  localparam int BL_LSB  = 0;
  localparam int BL_W    = 3;
  localparam int BT_BIT  = 3;
  localparam int CL_LSB  = 4;
  localparam int CL_W    = 3;
  localparam int RSV_LSB = CL_LSB + CL_W;

  // low three bits of {csN,rasN,casN,weN} with chip select active
  localparam logic [2:0] OP_MODE = 3'b000;
  localparam logic [2:0] OP_REF  = 3'b001;
  localparam logic [2:0] OP_PRE  = 3'b010;
  localparam logic [2:0] OP_ACT  = 3'b011;
  localparam logic [2:0] OP_WR   = 3'b100;
  localparam logic [2:0] OP_RD   = 3'b101;
  localparam logic [2:0] OP_BST  = 3'b110;

  typedef enum logic [3:0] {
    CMD_NOP     = 4'd0,
    CMD_MRS     = 4'd1,
    CMD_EMRS    = 4'd2,
    CMD_REF     = 4'd3,
    CMD_SR_IN   = 4'd4,
    CMD_SR_OUT  = 4'd5,
    CMD_ACT     = 4'd6,
    CMD_RD      = 4'd7,
    CMD_WR      = 4'd8,
    CMD_BST     = 4'd9,
    CMD_PRE_ONE = 4'd10,
    CMD_PRE_ALL = 4'd11,
    CMD_PD_PRE  = 4'd12,
    CMD_PD_ACT  = 4'd13,
    CMD_PD_OUT  = 4'd14
  } cmd_e;
  localparam int CMD_N = 15;

  typedef enum logic [1:0] {LP_NONE, LP_PD, LP_SR} lp_e;

  typedef struct packed {
    logic              baseLoad;
    logic [ADDR_W-1:0] opCode;
  } mode_req_t;
endpackage

// File: rtl/ddr_cmd_mode.sv
module ddr_cmd_mode
  import ddr_cmd_pkg::*;
#(
  parameter logic [3:0] RST_BL = 4'd4,
  parameter logic       RST_BT = 1'b0,
  parameter logic [3:0] RST_CL = 4'd6
) (
  input  logic       clk,
  input  logic       rstN,
  input  mode_req_t  req,
  output logic [3:0] burstLen,
  output logic       burstType,
  output logic [3:0] casLatHalf,
  output logic       modeErr
);
  logic [BL_W-1:0] blField;
  logic [CL_W-1:0] clField;
  logic            blOk, clOk, rsvOk, legal;
  logic [3:0]      blNext, clNext;

  assign blField = req.opCode[BL_LSB +: BL_W];
  assign clField = req.opCode[CL_LSB +: CL_W];

  always_comb begin
    blOk   = (blField == 3'd1) || (blField == 3'd2) || (blField == 3'd3);
    blNext = 4'd1 << blField[1:0];
    clOk   = 1'b1;
    unique case (clField)
      3'd2:    clNext = 4'd4;
      3'd3:    clNext = 4'd6;
      3'd6:    clNext = 4'd5;
      default: begin clNext = casLatHalf; clOk = 1'b0; end
    endcase
    rsvOk = ~|req.opCode[ADDR_W-1:RSV_LSB];
    legal = blOk && clOk && rsvOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstLen   <= RST_BL;
      burstType  <= RST_BT;
      casLatHalf <= RST_CL;
      modeErr    <= 1'b0;
    end else if (req.baseLoad) begin
      if (legal) begin
        burstLen   <= blNext;
        burstType  <= req.opCode[BT_BIT];
        casLatHalf <= clNext;
        modeErr    <= 1'b0;
      end else begin
        modeErr    <= 1'b1;
      end
    end
  end

  // R8: settings move only after a base mode load
  p_mode_only_on_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(req.baseLoad) |-> ($stable(burstLen) && $stable(burstType) && $stable(casLatHalf)));

  // R9: an error flag raise never comes with a settings change
  p_err_keeps_mode_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeErr) |-> ($stable(burstLen) && $stable(burstType) && $stable(casLatHalf)));
endmodule

// File: rtl/ddr_cmd_ctrl.sv
module ddr_cmd_ctrl
  import ddr_cmd_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  output logic [CMD_N-1:0]  cmdOneHot,
  output logic [BANK_W-1:0] cmdBank,
  output logic              autoPre,
  output mode_req_t         modeReq
);
  localparam int BANKS = 1 << BANK_W;

  logic             ckePrevQ;
  lp_e              lpQ, lpD;
  logic [BANKS-1:0] openQ, openD;
  cmd_e             nextCmd;
  logic [CMD_N-1:0] oneHotD;
  logic             apBit, isMode0, isMode1;

  assign apBit   = addr[AP_BIT];
  assign isMode0 = (ba[BANK_W-1:1] == '0) && !ba[0];
  assign isMode1 = (ba[BANK_W-1:1] == '0) &&  ba[0];

  always_comb begin
    nextCmd          = CMD_NOP;
    lpD              = lpQ;
    openD            = openQ;
    modeReq.baseLoad = 1'b0;
    modeReq.opCode   = addr;
    if (ckePrevQ && cke) begin
      if (!csN) begin
        unique case ({rasN, casN, weN})
          OP_MODE: begin
            if (isMode0) begin
              nextCmd          = CMD_MRS;
              modeReq.baseLoad = 1'b1;
            end else if (isMode1) begin
              nextCmd = CMD_EMRS;
            end
          end
          OP_REF: nextCmd = CMD_REF;
          OP_ACT: begin nextCmd = CMD_ACT; openD[ba] = 1'b1; end
          OP_RD:  begin nextCmd = CMD_RD; if (apBit) openD[ba] = 1'b0; end
          OP_WR:  begin nextCmd = CMD_WR; if (apBit) openD[ba] = 1'b0; end
          OP_BST: nextCmd = CMD_BST;
          OP_PRE: begin
            if (apBit) begin nextCmd = CMD_PRE_ALL; openD = '0; end
            else       begin nextCmd = CMD_PRE_ONE; openD[ba] = 1'b0; end
          end
          default: nextCmd = CMD_NOP;
        endcase
      end
    end else if (ckePrevQ && !cke) begin
      if (!csN && {rasN, casN, weN} == OP_REF) begin
        nextCmd = CMD_SR_IN;
        lpD     = LP_SR;
      end else begin
        nextCmd = (|openQ) ? CMD_PD_ACT : CMD_PD_PRE;
        lpD     = LP_PD;
      end
    end else if (!ckePrevQ && cke) begin
      nextCmd = (lpQ == LP_SR) ? CMD_SR_OUT : CMD_PD_OUT;
      lpD     = LP_NONE;
    end
  end

  always_comb begin
    oneHotD          = '0;
    oneHotD[nextCmd] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckePrevQ  <= 1'b1;
      lpQ       <= LP_NONE;
      openQ     <= '0;
      cmdOneHot <= CMD_N'(1);
      cmdBank   <= '0;
      autoPre   <= 1'b0;
    end else begin
      ckePrevQ  <= cke;
      lpQ       <= lpD;
      openQ     <= openD;
      cmdOneHot <= oneHotD;
      cmdBank   <= ba;
      autoPre   <= apBit && (nextCmd == CMD_RD || nextCmd == CMD_WR);
    end
  end

  // R1: one strobe per cycle
  p_one_hot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $countones(cmdOneHot) == 1);

  // R3: array commands only with clock enable high on both samples
  p_normal_needs_cke_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOneHot[CMD_ACT] || cmdOneHot[CMD_RD] || cmdOneHot[CMD_WR])
      |-> ($past(cke) && $past(ckePrevQ)));

  // R4: auto-precharge flag only beside read or write
  p_autopre_r4: assert property (@(posedge clk) disable iff (!rstN)
    autoPre |-> (cmdOneHot[CMD_RD] || cmdOneHot[CMD_WR]));

  // R5: self-refresh exit only on a rising clock enable
  p_sr_exit_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdOneHot[CMD_SR_OUT] |-> ($past(cke) && !$past(ckePrevQ)));

  // R6: active power-down only with a row open
  p_pd_type_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmdOneHot[CMD_PD_ACT] |-> $past(|openQ));
endmodule

// File: rtl/ddr_cmd_decoder.sv
module ddr_cmd_decoder
  import ddr_cmd_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  output logic [CMD_N-1:0]  cmdOneHot,
  output logic [BANK_W-1:0] cmdBank,
  output logic              autoPre,
  output logic [3:0]        burstLen,
  output logic              burstType,
  output logic [3:0]        casLatHalf,
  output logic              modeErr
);
  mode_req_t modeReq;

  ddr_cmd_ctrl #(.BANK_W(BANK_W)) ctrl (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addr(addr), .cmdOneHot(cmdOneHot), .cmdBank(cmdBank),
    .autoPre(autoPre), .modeReq(modeReq)
  );

  ddr_cmd_mode mode (
    .clk(clk), .rstN(rstN), .req(modeReq), .burstLen(burstLen),
    .burstType(burstType), .casLatHalf(casLatHalf), .modeErr(modeErr)
  );
endmodule

// File: tb/ddr_cmd_decoder_test.sv
module ddr_cmd_decoder_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, cke, csN, rasN, casN, weN;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic [14:0] cmdOneHot;
  logic [1:0]  cmdBank;
  logic        autoPre, burstType, modeErr;
  logic [3:0]  burstLen, casLatHalf;

  ddr_cmd_decoder uut (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addr(addr), .cmdOneHot(cmdOneHot), .cmdBank(cmdBank),
    .autoPre(autoPre), .burstLen(burstLen), .burstType(burstType),
    .casLatHalf(casLatHalf), .modeErr(modeErr)
  );

  int tests = 0;
  int fails = 0;
  logic [3:0] mOpen = 4'b0;
  logic [3:0] mBl = 4'd4;
  logic       mBt = 1'b0;
  logic [3:0] mCl = 4'd6;
  logic       mErr = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic k, input logic [3:0] code, input logic [1:0] b,
                      input logic [12:0] a);
    cke = k; {csN, rasN, casN, weN} = code; ba = b; addr = a;
    @(negedge clk);
  endtask

  function automatic int normIdx(input logic [3:0] c, input logic [1:0] b, input logic a10);
    if (c[3]) return 0;
    case (c[2:0])
      3'b000:  return (b == 2'd0) ? 1 : (b == 2'd1) ? 2 : 0;
      3'b001:  return 3;
      3'b011:  return 6;
      3'b101:  return 7;
      3'b100:  return 8;
      3'b110:  return 9;
      3'b010:  return a10 ? 11 : 10;
      default: return 0;
    endcase
  endfunction

  function automatic logic [12:0] op(input int blc, input int bt, input int clc);
    return {6'b0, 3'(clc), 1'(bt), 3'(blc)};
  endfunction

  task automatic chkMode(input string req);
    chk(req, burstLen, mBl);
    chk(req, burstType, mBt);
    chk(req, casLatHalf, mCl);
    chk(req, modeErr, mErr);
  endtask

  task automatic expCmd(input string req, input int idx);
    chk(req, cmdOneHot, 32'(15'd1 << idx));
  endtask

  task automatic pdIn(input logic [3:0] code, input string req);
    step(1'b0, code, 2'd0, 13'd0);
    expCmd(req, (|mOpen) ? 13 : 12);
  endtask

  task automatic pdOut(input string req);
    step(1'b1, 4'b0111, 2'd0, 13'd0);
    expCmd(req, 14);
  endtask

  initial begin
    rstN = 1'b0; cke = 1'b1; {csN, rasN, casN, weN} = 4'b0111; ba = 2'd0; addr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expCmd("R1 reset", 0);
    chkMode("R10 reset");

    // R2 R3 R4 R7: full sweep of codes, banks and bit 10 in normal mode
    for (int c = 0; c < 16; c++) begin
      for (int b = 0; b < 4; b++) begin
        for (int a = 0; a < 2; a++) begin
          int idx;
          idx = normIdx(4'(c), 2'(b), a[0]);
          step(1'b1, 4'(c), 2'(b), {2'b0, a[0], 10'b0});
          expCmd(idx == 0 ? "R2 nop" : "R3 decode", idx);
          chk("R1 count", $countones(cmdOneHot), 1);
          chk("R4 autoPre", autoPre, ((idx == 7 || idx == 8) && a[0]) ? 1 : 0);
          if (idx == 6 || idx == 7 || idx == 8 || idx == 10)
            chk("R3 bank", cmdBank, b);
          if (idx == 6) mOpen[b] = 1'b1;
          if ((idx == 7 || idx == 8) && a[0]) mOpen[b] = 1'b0;
          if (idx == 10) mOpen[b] = 1'b0;
          if (idx == 11) mOpen = 4'b0;
          if (idx == 1) begin mErr = 1'b1; chkMode("R9 sweep load"); end
        end
      end
    end

    // R8: every legal op-code combination
    for (int blc = 1; blc <= 3; blc++) begin
      for (int bt = 0; bt < 2; bt++) begin
        for (int k = 0; k < 3; k++) begin
          int clc;
          clc = (k == 0) ? 2 : (k == 1) ? 3 : 6;
          step(1'b1, 4'b0000, 2'd0, op(blc, bt, clc));
          expCmd("R8 load strobe", 1);
          mBl = 4'(1 << blc); mBt = bt[0]; mCl = (k == 0) ? 4'd4 : (k == 1) ? 4'd6 : 4'd5;
          mErr = 1'b0;
          chkMode("R8 legal");
        end
      end
    end

    // R9: illegal op-codes keep settings
    mErr = 1'b1;
    step(1'b1, 4'b0000, 2'd0, op(0, 0, 3)); chkMode("R9 bl 0");
    step(1'b1, 4'b0000, 2'd0, op(5, 0, 3)); chkMode("R9 bl 5");
    step(1'b1, 4'b0000, 2'd0, op(2, 0, 1)); chkMode("R9 cl 1");
    step(1'b1, 4'b0000, 2'd0, op(2, 0, 3) | 13'h200); chkMode("R9 reserved");
    step(1'b1, 4'b0000, 2'd0, op(2, 0, 3));
    mErr = 1'b0; mBl = 4'd4; mBt = 1'b0; mCl = 4'd6; chkMode("R8 recover");
    step(1'b1, 4'b0000, 2'd1, op(1, 1, 2));
    expCmd("R3 ext load", 2); chkMode("R9 ext load");
    step(1'b1, 4'b0000, 2'd2, op(1, 1, 2));
    expCmd("R3 bank2 load", 0); chkMode("R9 bank2 load");

    // R6 R7: power-down type follows open rows
    step(1'b1, 4'b0010, 2'd0, 13'h400); expCmd("R4 pre all", 11); mOpen = 4'b0;
    pdIn(4'b0111, "R6 pd idle");
    step(1'b0, 4'b0101, 2'd1, 13'd0); expCmd("R6 low read", 0);
    step(1'b0, 4'b0011, 2'd1, 13'd0); expCmd("R6 low act", 0);
    pdOut("R6 exit");
    step(1'b1, 4'b0011, 2'd2, 13'd0); expCmd("R7 act", 6); mOpen[2] = 1'b1;
    pdIn(4'b1111, "R7 pd open");
    pdOut("R6 exit");
    step(1'b1, 4'b0101, 2'd2, 13'h400); expCmd("R7 read ap", 7);
    chk("R4 read ap", autoPre, 1); mOpen[2] = 1'b0;
    pdIn(4'b0111, "R7 after ap");
    pdOut("R6 exit");
    step(1'b1, 4'b0011, 2'd1, 13'd0); mOpen[1] = 1'b1;
    step(1'b1, 4'b0010, 2'd0, 13'd0); expCmd("R4 pre one", 10);
    pdIn(4'b0111, "R7 other bank pre");
    pdOut("R6 exit");
    step(1'b1, 4'b0010, 2'd1, 13'd0); mOpen[1] = 1'b0;
    pdIn(4'b0111, "R7 pre one");
    pdOut("R6 exit");
    step(1'b1, 4'b0011, 2'd3, 13'd0); mOpen[3] = 1'b1;
    pdIn(4'b0010, "R6 pre at fall");
    pdOut("R6 exit");
    pdIn(4'b0111, "R6 pre ignored");
    pdOut("R6 exit");
    step(1'b1, 4'b0010, 2'd0, 13'h400); mOpen = 4'b0;

    // R5: self refresh
    step(1'b0, 4'b0001, 2'd0, 13'd0); expCmd("R5 sr entry", 4);
    step(1'b0, 4'b0111, 2'd0, 13'd0); expCmd("R5 sr hold", 0);
    step(1'b0, 4'b0001, 2'd0, 13'd0); expCmd("R5 sr hold ref", 0);
    step(1'b1, 4'b0111, 2'd0, 13'd0); expCmd("R5 sr exit", 5);
    step(1'b1, 4'b0111, 2'd0, 13'd0); expCmd("R5 after exit", 0);
    pdIn(4'b1001, "R5 deselected ref");
    pdOut("R5 pd exit");
    step(1'b1, 4'b0011, 2'd0, 13'd0); expCmd("R3 act after", 6);
    chk("R3 act bank", cmdBank, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule